// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit works out how many vector elements a machine can hold at once. It also grants vector lengths to software against that limit. A configure strobe carries four values: how many integer registers each element uses, how many floating-point registers each element uses, how many registers one bank holds, and an 8-bit mask of the enabled banks. These values start a short sequential division. The result, times the number of enabled banks and capped at a fixed hardware element limit, becomes the new maximum length.

A set-length strobe carries a requested length. When accepted, the current vector length becomes the smaller of that request and the maximum. While the division runs, `busy_o` is high. Requests of either kind made during that time are not accepted, so a requester holds its strobe until `busy_o` falls.

Top module: `vlcfg_unit`

## Requirements
- R1: After reset, `maxlen_o` is 32, `vlen_o` is 0 and `busy_o` is 0. These values match 8 enabled banks, 256 registers per bank and 32 integer plus 32 floating-point registers per element.
- R2: When integer use plus floating-point use is below 2, the new maximum is registers-per-bank times the bank count, before the cap.
- R3: Otherwise, the new maximum is floor(registers-per-bank / (integer use + floating-point use - 1)) times the bank count, before the cap.
- R4: `maxlen_o` never exceeds MAX_ELEM (32 by default). A larger product reads as MAX_ELEM.
- R5: The bank count is the number of ones in `cfg_bank_mask_i`, where bit i set means bank i is enabled. An all-zero mask gives a maximum of 0.
- R6: A configure strobe seen while `busy_o` is low is accepted at that clock edge. `busy_o` then stays high for exactly W_RPB (9) cycles. `maxlen_o` takes its new value at the edge where `busy_o` falls.
- R7: A configure strobe seen while `busy_o` is high is ignored. The running computation finishes with the values accepted earlier.
- R8: A set-length strobe seen while `busy_o` is low sets `vlen_o` at that edge to min(`maxlen_o`, `setvl_len_i`).
- R9: A set-length strobe seen while `busy_o` is high leaves `vlen_o` unchanged. If it is held until `busy_o` falls, it is then applied against the new maximum.
- R10: When both strobes arrive in the same idle cycle, both are accepted. The set-length request is clamped against the maximum that was in place before that edge.
- R11: While `busy_o` is low, `maxlen_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid_i | input | 1 | Configure strobe |
| cfg_int_use_i | input | W_USE (6) | Integer registers per element |
| cfg_fp_use_i | input | W_USE (6) | Floating-point registers per element |
| cfg_regs_per_bank_i | input | W_RPB (9) | Registers in one bank |
| cfg_bank_mask_i | input | NBANK (8) | Enabled-bank mask, bit i = bank i |
| setvl_valid_i | input | 1 | Set-length strobe |
| setvl_len_i | input | W_REQ (16) | Requested vector length |
| busy_o | output | 1 | Division in progress; both strobes are held off |
| maxlen_o | output | W_LEN (6) | Registered maximum vector length |
| vlen_o | output | W_LEN (6) | Current vector length |

## Verification
Two functions can meet in one cycle: a configuration being accepted or finishing, and a length request being accepted. The bench raises both strobes in the same idle cycle and expects the granted length to be clamped by the old maximum, while the new maximum appears nine cycles later. It also holds a length request across a whole division and expects no change until `busy_o` falls, then a grant clamped by the freshly computed maximum.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

    typedef enum logic [0:0] {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/vlcfg_popcount.sv
module vlcfg_popcount #(
    parameter int N     = 8,
    parameter int W_CNT = $clog2(N + 1)
) (
    input  logic [N-1:0]     vec_i,
    output logic [W_CNT-1:0] cnt_o
);

    logic [W_CNT-1:0] part [N+1];

    assign part[0] = '0;

    for (genvar gi = 0; gi < N; gi++) begin : g_sum
        assign part[gi+1] = part[gi] + W_CNT'(vec_i[gi]);
    end

    assign cnt_o = part[N];

endmodule

// File: rtl/vlcfg_clamp.sv
module vlcfg_clamp #(
    parameter int W_IN  = 16,
    parameter int W_LIM = 6
) (
    input  logic [W_IN-1:0]  val_i,
    input  logic [W_LIM-1:0] lim_i,
    output logic [W_LIM-1:0] out_o
);

    localparam int W_MAX = (W_IN > W_LIM) ? W_IN : W_LIM;

    logic [W_MAX-1:0] val_w;
    logic [W_MAX-1:0] lim_w;

    assign val_w = W_MAX'(val_i);
    assign lim_w = W_MAX'(lim_i);
    assign out_o = (val_w > lim_w) ? lim_i : W_LIM'(val_w);

endmodule

// File: rtl/vlcfg_divider.sv
module vlcfg_divider
    import vlcfg_pkg::*;
#(
    parameter int W_NUM = 9,
    parameter int W_DEN = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [W_NUM-1:0] num_i,
    input  logic [W_DEN-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [W_NUM-1:0] quot_o
);

    localparam int W_CNT = $clog2(W_NUM + 1);

    typedef struct packed {
        div_state_e       st;
        logic [W_CNT-1:0] cnt;
        logic [W_DEN:0]   rem;
        logic [W_NUM-1:0] quo;
        logic [W_DEN-1:0] den;
    } div_s;

    div_s q, d;

    logic [W_DEN:0]   rem_sh;
    logic [W_DEN:0]   rem_step;
    logic             qbit;
    logic [W_NUM-1:0] quo_step;

    always_comb begin
        rem_sh   = {q.rem[W_DEN-1:0], q.quo[W_NUM-1]};
        qbit     = (rem_sh >= {1'b0, q.den});
        rem_step = qbit ? (rem_sh - {1'b0, q.den}) : rem_sh;
        quo_step = {q.quo[W_NUM-2:0], qbit};

        d      = q;
        done_o = 1'b0;
        case (q.st)
            DIV_IDLE: begin
                if (start_i) begin
                    d.st  = DIV_RUN;
                    d.cnt = W_CNT'(W_NUM);
                    d.rem = '0;
                    d.quo = num_i;
                    d.den = den_i;
                end
            end
            default: begin
                d.rem = rem_step;
                d.quo = quo_step;
                d.cnt = q.cnt - W_CNT'(1);
                if (q.cnt == W_CNT'(1)) begin
                    d.st   = DIV_IDLE;
                    done_o = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: DIV_IDLE, cnt: '0, rem: '0, quo: '0, den: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st == DIV_RUN);
    assign quot_o = quo_step;

endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit #(
    parameter int NBANK    = 8,
    parameter int W_USE    = 6,
    parameter int W_RPB    = 9,
    parameter int W_REQ    = 16,
    parameter int MAX_ELEM = 32,
    parameter int RST_RPB  = 256,
    parameter int RST_USE  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_valid_i,
    input  logic [W_USE-1:0]                cfg_int_use_i,
    input  logic [W_USE-1:0]                cfg_fp_use_i,
    input  logic [W_RPB-1:0]                cfg_regs_per_bank_i,
    input  logic [NBANK-1:0]                cfg_bank_mask_i,
    input  logic                            setvl_valid_i,
    input  logic [W_REQ-1:0]                setvl_len_i,
    output logic                            busy_o,
    output logic [$clog2(MAX_ELEM+1)-1:0]   maxlen_o,
    output logic [$clog2(MAX_ELEM+1)-1:0]   vlen_o
);

    localparam int W_LEN  = $clog2(MAX_ELEM + 1);
    localparam int W_SUM  = W_USE + 1;
    localparam int W_BCNT = $clog2(NBANK + 1);
    localparam int W_PROD = W_RPB + W_BCNT;
    localparam int RST_S  = 2 * RST_USE;
    localparam int RST_Q  = (RST_S < 2) ? RST_RPB : RST_RPB / (RST_S - 1);
    localparam int RST_P  = RST_Q * NBANK;
    localparam int RST_MX = (RST_P > MAX_ELEM) ? MAX_ELEM : RST_P;

    typedef struct packed {
        logic [NBANK-1:0] mask;
        logic [W_LEN-1:0] maxlen;
        logic [W_LEN-1:0] vlen;
    } st_s;

    st_s q, d;

    logic              div_busy;
    logic              div_done;
    logic [W_RPB-1:0]  div_quot;
    logic [W_SUM-1:0]  use_sum;
    logic [W_SUM-1:0]  den;
    logic              cfg_take;
    logic              setvl_take;
    logic [W_BCNT-1:0] bank_cnt;
    logic [W_PROD-1:0] prod;
    logic [W_LEN-1:0]  max_capped;
    logic [W_LEN-1:0]  vl_clamped;

    assign use_sum    = W_SUM'(cfg_int_use_i) + W_SUM'(cfg_fp_use_i);
    assign den        = (use_sum < W_SUM'(2)) ? W_SUM'(1) : (use_sum - W_SUM'(1));
    assign cfg_take   = cfg_valid_i & ~div_busy;
    assign setvl_take = setvl_valid_i & ~div_busy;
    assign prod       = W_PROD'(div_quot) * W_PROD'(bank_cnt);

    vlcfg_divider #(
        .W_NUM (W_RPB),
        .W_DEN (W_SUM)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (cfg_take),
        .num_i   (cfg_regs_per_bank_i),
        .den_i   (den),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .quot_o  (div_quot)
    );

    vlcfg_popcount #(
        .N     (NBANK),
        .W_CNT (W_BCNT)
    ) u_pop (
        .vec_i (q.mask),
        .cnt_o (bank_cnt)
    );

    vlcfg_clamp #(
        .W_IN  (W_PROD),
        .W_LIM (W_LEN)
    ) u_cap (
        .val_i (prod),
        .lim_i (W_LEN'(MAX_ELEM)),
        .out_o (max_capped)
    );

    vlcfg_clamp #(
        .W_IN  (W_REQ),
        .W_LIM (W_LEN)
    ) u_vl (
        .val_i (setvl_len_i),
        .lim_i (q.maxlen),
        .out_o (vl_clamped)
    );

    always_comb begin
        d = q;
        if (cfg_take) begin
            d.mask = cfg_bank_mask_i;
        end
        if (div_done) begin
            d.maxlen = max_capped;
        end
        if (setvl_take) begin
            d.vlen = vl_clamped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{mask: '1, maxlen: W_LEN'(RST_MX), vlen: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o   = div_busy;
    assign maxlen_o = q.maxlen;
    assign vlen_o   = q.vlen;

endmodule

// File: rtl/vlcfg_chk.sv
module vlcfg_chk #(
    parameter int W_LEN    = 6,
    parameter int W_REQ    = 16,
    parameter int MAX_ELEM = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_valid_i,
    input logic             setvl_valid_i,
    input logic [W_REQ-1:0] setvl_len_i,
    input logic             busy_o,
    input logic [W_LEN-1:0] maxlen_o,
    input logic [W_LEN-1:0] vlen_o
);

    localparam int W_CMP = (W_REQ > W_LEN) ? W_REQ : W_LEN;

    logic [W_LEN-1:0] exp_vl;

    always_comb begin
        exp_vl = (W_CMP'(setvl_len_i) > W_CMP'(maxlen_o)) ? maxlen_o : W_LEN'(setvl_len_i);
    end

    a_r4_cap: assert property (@(posedge clk) disable iff (!rst_n)
        maxlen_o <= W_LEN'(MAX_ELEM));

    a_r6_busy_after_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_i && !busy_o) |=> busy_o);

    a_r11_max_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(maxlen_o));

    a_r9_vl_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(vlen_o));

    a_r8_setvl_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (setvl_valid_i && !busy_o) |=> (vlen_o == $past(exp_vl)));

endmodule

bind vlcfg_unit vlcfg_chk #(
    .W_LEN    (W_LEN),
    .W_REQ    (W_REQ),
    .MAX_ELEM (MAX_ELEM)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_valid_i   (cfg_valid_i),
    .setvl_valid_i (setvl_valid_i),
    .setvl_len_i   (setvl_len_i),
    .busy_o        (busy_o),
    .maxlen_o      (maxlen_o),
    .vlen_o        (vlen_o)
);

// File: tb/vlcfg_unit_bench.sv
`timescale 1ns/1ps
module vlcfg_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [5:0]  cfg_int = '0;
    logic [5:0]  cfg_fp = '0;
    logic [8:0]  cfg_rpb = '0;
    logic [7:0]  cfg_mask = '0;
    logic        setvl_valid = 1'b0;
    logic [15:0] setvl_len = '0;
    logic        busy;
    logic [5:0]  maxlen;
    logic [5:0]  vlen;

    int total = 0;
    int bad = 0;
    int cur_max = 32;
    int cur_vl = 0;

    always #5 clk = ~clk;

    vlcfg_unit u_vlcfg_unit (
        .clk                 (clk),
        .rst_n               (rst_n),
        .cfg_valid_i         (cfg_valid),
        .cfg_int_use_i       (cfg_int),
        .cfg_fp_use_i        (cfg_fp),
        .cfg_regs_per_bank_i (cfg_rpb),
        .cfg_bank_mask_i     (cfg_mask),
        .setvl_valid_i       (setvl_valid),
        .setvl_len_i         (setvl_len),
        .busy_o              (busy),
        .maxlen_o            (maxlen),
        .vlen_o              (vlen)
    );

    function automatic int model_max(int iu, int fu, int rpb, logic [7:0] mask);
        int s = iu + fu;
        int q = (s < 2) ? rpb : rpb / (s - 1);
        int p = q * $countones(mask);
        return (p > 32) ? 32 : p;
    endfunction

    function automatic int model_vl(int mx, int req);
        return (req < mx) ? req : mx;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_start(input int iu, input int fu, input int rpb, input logic [7:0] mask);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_int   = 6'(iu);
        cfg_fp    = 6'(fu);
        cfg_rpb   = 9'(rpb);
        cfg_mask  = mask;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_cfg(input int iu, input int fu, input int rpb, input logic [7:0] mask,
                           input string req);
        int n;
        int e;
        e = model_max(iu, fu, rpb, mask);
        cfg_start(iu, fu, rpb, mask);
        wait_idle(n);
        check(n == 9, "R6", n, 9);
        check(int'(maxlen) == e, req, int'(maxlen), e);
        cur_max = e;
    endtask

    task automatic run_setvl(input int req);
        int e;
        e = model_vl(cur_max, req);
        @(negedge clk);
        setvl_valid = 1'b1;
        setvl_len   = 16'(req);
        @(negedge clk);
        setvl_valid = 1'b0;
        check(int'(vlen) == e, "R8", int'(vlen), e);
        cur_vl = e;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(maxlen) == 32, "R1", int'(maxlen), 32);
        check(int'(vlen) == 0, "R1", int'(vlen), 0);
        check(busy == 1'b0, "R1", int'(busy), 0);

        // directed: R2 with cap R4, R2 uncapped with R5 mask, R3, R5 zero mask
        run_cfg(0, 0, 256, 8'hFF, "R4");
        run_cfg(1, 0, 3, 8'h05, "R2");
        run_cfg(3, 2, 20, 8'h81, "R3");
        run_cfg(5, 5, 100, 8'h00, "R5");
        run_cfg(32, 31, 256, 8'h0F, "R3");

        // R8 clamp cases at maximum 16
        run_setvl(5);
        run_setvl(16);
        run_setvl(1000);
        run_setvl(0);

        // R11: idle cycles keep maximum
        repeat (5) @(negedge clk);
        check(int'(maxlen) == 16, "R11", int'(maxlen), 16);

        // R7: second configure while busy is ignored
        cfg_start(32, 31, 256, 8'h03);
        cfg_valid = 1'b1;
        cfg_int   = 6'd0;
        cfg_fp    = 6'd0;
        cfg_mask  = 8'hFF;
        @(negedge clk);
        cfg_valid = 1'b0;
        wait_idle(n);
        check(int'(maxlen) == 8, "R7", int'(maxlen), 8);
        cur_max = 8;
        run_setvl(3);

        // R9: length request held across a division
        cfg_start(1, 1, 20, 8'h01);
        setvl_valid = 1'b1;
        setvl_len   = 16'd25;
        @(negedge clk);
        check(int'(vlen) == 3, "R9", int'(vlen), 3);
        wait_idle(n);
        check(int'(vlen) == 3, "R9", int'(vlen), 3);
        @(negedge clk);
        setvl_valid = 1'b0;
        check(int'(vlen) == 20, "R9", int'(vlen), 20);
        cur_max = 20;

        // R10: both strobes in the same idle cycle
        @(negedge clk);
        cfg_valid   = 1'b1;
        cfg_int     = 6'd0;
        cfg_fp      = 6'd0;
        cfg_rpb     = 9'd7;
        cfg_mask    = 8'h01;
        setvl_valid = 1'b1;
        setvl_len   = 16'd30;
        @(negedge clk);
        cfg_valid   = 1'b0;
        setvl_valid = 1'b0;
        check(int'(vlen) == 20, "R10", int'(vlen), 20);
        check(busy == 1'b1, "R10", int'(busy), 1);
        wait_idle(n);
        check(int'(maxlen) == 7, "R10", int'(maxlen), 7);
        cur_max = 7;

        // random legal configurations (R2, R3 by sum) and requests (R8)
        for (int it = 0; it < 40; it++) begin
            int iu = $urandom_range(0, 32);
            int fu = $urandom_range(0, 32);
            int rpb = $urandom_range(0, 256);
            logic [7:0] mk = 8'($urandom);
            run_cfg(iu, fu, rpb, mk, (iu + fu < 2) ? "R2" : "R3");
            run_setvl($urandom_range(0, 63));
            run_setvl($urandom_range(0, 40));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule